// File: doc/BRIEF.md
# Word-packed colour palette loader

This block is a colour lookup table with 256 entries. Each entry holds an 8-bit red, an 8-bit green and an 8-bit blue component. A host fills the table through two write strobes. A pointer write selects an aligned group of four entries. Data-word writes then carry 32-bit words whose bytes are consumed in a continuous red, green, blue stream. Every three words load four entries, and a colour triplet may straddle two words, so the block keeps track of which component comes next from one word to the following one.

A separate lookup port takes a pixel index and returns that entry's 24-bit colour one cycle later. A colour enters the table only after its blue byte has arrived. After three words the pointer moves on to the next group by itself, so the host can stream a long run of words after a single pointer write.

Top module: `pal_loader`

## Requirements
- R1: A synchronous active-high reset sets the load pointer to group 0 and the phase to the first word of a group, and clears the lookup output to zero. Data words written after reset with no pointer write load entries 0 to 3.
- R2: A pointer write selects the group at index bits [IDX_W-1:2]. The two low bits are ignored, so writing 14 loads entries 12 to 15.
- R3: Bytes are consumed most significant first, in the order R, G, B per entry. Word 0 supplies R,G,B of entry n and R of n+1. Word 1 supplies G,B of n+1 and R,G of n+2. Word 2 supplies B of n+2 and R,G,B of n+3. The lookup output is {R[23:16], G[15:8], B[7:0]}.
- R4: Three data words load exactly the four entries of the current group, and no other entry changes.
- R5: After the third word the pointer moves to the next group. After the last group it wraps to group 0.
- R6: A pointer write returns the phase to the first word of a group, and any partly received entry is discarded.
- R7: An entry changes only in the cycle its blue byte is written. A lookup never shows an entry with only some of its components updated.
- R8: A lookup returns the colour one cycle after the index is presented. If a commit to the same entry happens in that cycle, the lookup returns the old colour, and the next lookup returns the new one.
- R9: When a pointer write and a data write happen in the same cycle, the pointer write wins and the data word is ignored.
- R10: Without a data write, the table contents do not change, whatever the data input carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ptr_we | input | 1 | Pointer write strobe |
| ptr_wdata | input | IDX_W | Starting entry index (multiple of four) |
| word_we | input | 1 | Data-word write strobe |
| word_wdata | input | 32 | Packed colour bytes, most significant first |
| look_idx | input | IDX_W | Pixel index for lookup |
| look_color | output | 24 | Colour of the looked-up entry, one cycle later |

## Verification
The bench builds the loader with ENTRIES=32, which gives eight groups. This size lets it stream over the whole table, cross the wrap from the last group back to group 0, and read back every entry, all in a few hundred cycles. Expected colours come from a byte image formed arithmetically from a seed and the byte offset. The partial-group, pointer-reset and same-cycle lookup cases are then aimed at individual entries and their neighbours.

// File: rtl/pal_pkg.sv
package pal_pkg;
    localparam int COMP_W          = 8;
    localparam int WORD_W          = 32;
    localparam int BYTES_PER_WORD  = WORD_W / COMP_W;
    localparam int GROUP_SZ        = 4;
    localparam int SLOT_W          = $clog2(GROUP_SZ);
    localparam int COLOR_W         = 3 * COMP_W;

    typedef logic [COMP_W-1:0] comp_t;

    typedef struct packed {
        comp_t r;
        comp_t g;
        comp_t b;
    } rgb_t;

    typedef enum logic [1:0] {
        PH_W0 = 2'd0,
        PH_W1 = 2'd1,
        PH_W2 = 2'd2
    } phase_e;

    typedef struct packed {
        logic              en;
        logic [SLOT_W-1:0] slot;
        rgb_t              color;
    } commit_t;

    // Byte k of a word, k = 0 being the most significant byte.
    function automatic comp_t word_byte(logic [WORD_W-1:0] w, int k);
        return w[WORD_W-1-COMP_W*k -: COMP_W];
    endfunction

    function automatic phase_e next_phase(phase_e p);
        case (p)
            PH_W0:   return PH_W1;
            PH_W1:   return PH_W2;
            default: return PH_W0;
        endcase
    endfunction
endpackage

// File: rtl/pal_seq.sv
module pal_seq
    import pal_pkg::*;
#(
    parameter int GRP_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ptr_we,
    input  logic [GRP_W-1:0] ptr_grp,
    input  logic             word_acc,
    output logic [GRP_W-1:0] grp,
    output phase_e           phase
);
    always_ff @(posedge clk) begin
        if (rst) begin
            grp   <= '0;
            phase <= PH_W0;
        end else if (ptr_we) begin
            grp   <= ptr_grp;
            phase <= PH_W0;
        end else if (word_acc) begin
            phase <= next_phase(phase);
            if (phase == PH_W2)
                grp <= grp + 1'b1;
        end
    end

    // R3
    phase_legal_chk: assert property (@(posedge clk) disable iff (rst)
        logic'(phase != PH_W0) |-> (phase == PH_W1 || phase == PH_W2));

    // R5
    grp_advance_chk: assert property (@(posedge clk) disable iff (rst)
        (word_acc && !ptr_we && phase == PH_W2) |=>
            (phase == PH_W0 && grp == GRP_W'($past(grp) + 1'b1)));

    // R6
    ptr_load_chk: assert property (@(posedge clk) disable iff (rst)
        ptr_we |=> (phase == PH_W0 && grp == $past(ptr_grp)));
endmodule

// File: rtl/pal_unpack.sv
module pal_unpack
    import pal_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              word_acc,
    input  phase_e            phase,
    input  logic [WORD_W-1:0] word,
    output commit_t           commit_a,
    output commit_t           commit_b
);
    comp_t bytes_w [BYTES_PER_WORD];
    comp_t held_r, held_g;
    comp_t nxt_r, nxt_g;

    for (genvar k = 0; k < BYTES_PER_WORD; k++) begin : g_bytes
        assign bytes_w[k] = word_byte(word, k);
    end

    always_comb begin
        commit_a = '0;
        commit_b = '0;
        nxt_r    = held_r;
        nxt_g    = held_g;
        case (phase)
            PH_W0: begin
                commit_a.slot  = SLOT_W'(0);
                commit_a.color = '{r: bytes_w[0], g: bytes_w[1], b: bytes_w[2]};
                nxt_r          = bytes_w[3];
            end
            PH_W1: begin
                commit_a.slot  = SLOT_W'(1);
                commit_a.color = '{r: held_r, g: bytes_w[0], b: bytes_w[1]};
                nxt_r          = bytes_w[2];
                nxt_g          = bytes_w[3];
            end
            default: begin
                commit_a.slot  = SLOT_W'(2);
                commit_a.color = '{r: held_r, g: held_g, b: bytes_w[0]};
                commit_b.slot  = SLOT_W'(3);
                commit_b.color = '{r: bytes_w[1], g: bytes_w[2], b: bytes_w[3]};
                commit_b.en    = word_acc;
            end
        endcase
        commit_a.en = word_acc;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            held_r <= '0;
            held_g <= '0;
        end else if (word_acc) begin
            held_r <= nxt_r;
            held_g <= nxt_g;
        end
    end
endmodule

// File: rtl/pal_table.sv
module pal_table
    import pal_pkg::*;
#(
    parameter int ENTRIES = 256,
    parameter int IDX_W   = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wa_en,
    input  logic [IDX_W-1:0] wa_idx,
    input  rgb_t             wa_data,
    input  logic             wb_en,
    input  logic [IDX_W-1:0] wb_idx,
    input  rgb_t             wb_data,
    input  logic [IDX_W-1:0] rd_idx,
    output rgb_t             rd_data
);
    rgb_t mem [ENTRIES];

    always_ff @(posedge clk) begin
        for (int e = 0; e < ENTRIES; e++) begin
            if (wa_en && wa_idx == IDX_W'(e))
                mem[e] <= wa_data;
            else if (wb_en && wb_idx == IDX_W'(e))
                mem[e] <= wb_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            rd_data <= '0;
        else
            rd_data <= mem[rd_idx];
    end

    // R4
    distinct_slots_chk: assert property (@(posedge clk) disable iff (rst)
        (wa_en && wb_en) |-> (wa_idx != wb_idx));

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(wa_en) && !$past(wb_en) && $stable(rd_idx))
            |=> $stable(rd_data));
endmodule

// File: rtl/pal_loader.sv
module pal_loader
    import pal_pkg::*;
#(
    parameter  int ENTRIES = 256,
    localparam int IDX_W   = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ptr_we,
    input  logic [IDX_W-1:0]   ptr_wdata,
    input  logic               word_we,
    input  logic [WORD_W-1:0]  word_wdata,
    input  logic [IDX_W-1:0]   look_idx,
    output logic [COLOR_W-1:0] look_color
);
    localparam int GRP_W = IDX_W - SLOT_W;

    logic             word_acc;
    logic [GRP_W-1:0] grp;
    phase_e           phase;
    commit_t          ca, cb;
    rgb_t             rd_rgb;

    // A pointer write in the same cycle takes precedence over data.
    assign word_acc = word_we && !ptr_we;

    pal_seq #(.GRP_W(GRP_W)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .ptr_we   (ptr_we),
        .ptr_grp  (ptr_wdata[IDX_W-1:SLOT_W]),
        .word_acc (word_acc),
        .grp      (grp),
        .phase    (phase)
    );

    pal_unpack u_unpack (
        .clk      (clk),
        .rst      (rst),
        .word_acc (word_acc),
        .phase    (phase),
        .word     (word_wdata),
        .commit_a (ca),
        .commit_b (cb)
    );

    pal_table #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_table (
        .clk     (clk),
        .rst     (rst),
        .wa_en   (ca.en),
        .wa_idx  ({grp, ca.slot}),
        .wa_data (ca.color),
        .wb_en   (cb.en),
        .wb_idx  ({grp, cb.slot}),
        .wb_data (cb.color),
        .rd_idx  (look_idx),
        .rd_data (rd_rgb)
    );

    assign look_color = rd_rgb;
endmodule

// File: tb/test_pal_loader.sv
`timescale 1ns/1ps
module test_pal_loader;
    localparam int N  = 32;
    localparam int IW = $clog2(N);
    localparam int G  = N / 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ptr_we = 1'b0;
    logic [IW-1:0] ptr_wdata = '0;
    logic          word_we = 1'b0;
    logic [31:0]   word_wdata = '0;
    logic [IW-1:0] look_idx = '0;
    logic [23:0]   look_color;

    int errors = 0;
    int checks = 0;
    logic [23:0] model [N];

    always #5 clk = ~clk;

    pal_loader #(.ENTRIES(N)) i_pal_loader (
        .clk(clk), .rst(rst), .ptr_we(ptr_we), .ptr_wdata(ptr_wdata),
        .word_we(word_we), .word_wdata(word_wdata),
        .look_idx(look_idx), .look_color(look_color)
    );

    function automatic logic [7:0] byt(int seed, int k);
        return 8'((seed * 37 + k * 101 + 11) % 256);
    endfunction
    function automatic logic [31:0] wordv(int seed, int j);
        return {byt(seed, 4*j), byt(seed, 4*j+1), byt(seed, 4*j+2), byt(seed, 4*j+3)};
    endfunction
    function automatic logic [23:0] entv(int seed, int m);
        return {byt(seed, 3*m), byt(seed, 3*m+1), byt(seed, 3*m+2)};
    endfunction

    task automatic check(string req, logic [23:0] act, logic [23:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%06h expected=%06h", req, act, exp);
        end
    endtask

    task automatic wr_ptr(int idx);
        @(negedge clk); ptr_we = 1'b1; ptr_wdata = IW'(idx);
        @(negedge clk); ptr_we = 1'b0;
    endtask
    task automatic wr_word(logic [31:0] w);
        @(negedge clk); word_we = 1'b1; word_wdata = w;
        @(negedge clk); word_we = 1'b0; word_wdata = ~w;
    endtask
    task automatic stream(int seed, int nwords);
        for (int j = 0; j < nwords; j++) wr_word(wordv(seed, j));
    endtask
    task automatic set_model(int s0, int seed, int nent);
        for (int m = 0; m < nent; m++) model[(s0 + m) % N] = entv(seed, m);
    endtask
    task automatic look(int idx, output logic [23:0] v);
        @(negedge clk); look_idx = IW'(idx);
        @(negedge clk); v = look_color;
    endtask
    task automatic check_entry(string req, int idx);
        logic [23:0] v;
        look(idx, v);
        check(req, v, model[idx % N]);
    endtask

    initial begin
        #(200000 * 10);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [23:0] v;
        repeat (3) @(negedge clk);
        check("R1 reset output", look_color, 24'h0);
        rst = 1'b0;

        // R1, R3: no pointer write after reset, explicit byte order
        wr_word(32'h11223344);
        wr_word(32'h55667788);
        wr_word(32'h99AABBCC);
        model[0] = 24'h112233; model[1] = 24'h445566;
        model[2] = 24'h778899; model[3] = 24'hAABBCC;
        for (int e = 0; e < 4; e++) check_entry("R1 R3 group0", e);

        // R4: full sweep over every group
        wr_ptr(0);
        stream(2, 3 * G);
        set_model(0, 2, N);
        for (int e = 0; e < N; e++) check_entry("R4 sweep", e);

        // R5: continuing stream wraps to group 0
        stream(3, 3);
        set_model(0, 3, 4);
        for (int e = 0; e < 5; e++) check_entry("R5 wrap", e);
        wr_ptr(N - 4);
        stream(4, 6);
        set_model(N - 4, 4, 8);
        for (int e = N - 5; e < N + 5; e++) check_entry("R5 cross", e);

        // R2: low pointer bits ignored
        wr_ptr(14);
        stream(5, 3);
        set_model(12, 5, 4);
        for (int e = 11; e < 17; e++) check_entry("R2 group select", e);

        // R7, R6: partial group then pointer reset
        wr_ptr(20);
        wr_word(wordv(9, 0));
        model[20] = entv(9, 0);
        check_entry("R7 commit on blue", 20);
        check_entry("R7 no half entry", 21);
        wr_word(wordv(9, 1));
        model[21] = entv(9, 1);
        check_entry("R7 second entry", 21);
        check_entry("R7 staged held", 22);
        wr_ptr(20);
        check_entry("R6 partial discarded", 22);
        stream(6, 3);
        set_model(20, 6, 4);
        for (int e = 19; e < 25; e++) check_entry("R6 phase reset", e);

        // R8: lookup and commit to the same entry in one cycle
        wr_ptr(8);
        @(negedge clk);
        word_we = 1'b1; word_wdata = wordv(7, 0); look_idx = IW'(8);
        @(negedge clk);
        word_we = 1'b0;
        check("R8 old value", look_color, model[8]);
        @(negedge clk);
        check("R8 new value", look_color, entv(7, 0));
        wr_word(wordv(7, 1));
        wr_word(wordv(7, 2));
        set_model(8, 7, 4);
        for (int e = 8; e < 12; e++) check_entry("R8 group", e);

        // R9: pointer write and data write together
        @(negedge clk);
        ptr_we = 1'b1; ptr_wdata = IW'(24); word_we = 1'b1; word_wdata = 32'hDEADBEEF;
        @(negedge clk);
        ptr_we = 1'b0; word_we = 1'b0;
        stream(8, 3);
        set_model(24, 8, 4);
        for (int e = 12; e < 16; e++) check_entry("R9 old group kept", e);
        for (int e = 23; e < 29; e++) check_entry("R9 pointer wins", e);

        // R10: data input toggles without a strobe
        look(26, v);
        for (int c = 0; c < 6; c++) begin
            @(negedge clk); word_wdata = 32'h01010101 * c;
            check("R10 idle hold", look_color, model[26]);
        end
        for (int e = 0; e < N; e++) check_entry("R10 final table", e);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule